// File: doc/BRIEF.md
# Supply Protection Sequencing Controller

This block sequences the enable of an external pass switch on a supply input and drives an active-low fault flag. Its inputs are three asynchronous logic levels: an undervoltage-OK comparator output, an overvoltage comparator output and an active-low enable pin. Each input passes through a two-flop synchronizer before the state machine sees it. The block produces a gate-enable level and a flag-low request for an open-drain driver.

The input must be valid for a qualification interval before the switch is closed. The overvoltage level is examined only when that interval ends. Once the switch is closed, the flag stays low for a further blanking interval, and is then released. An overvoltage while the switch is closed opens it at once and pulls the flag low, with no filtering. Loss of the undervoltage-OK level returns the block to standby from any state. A high level on the enable pin opens the switch without reporting a fault, but it cannot hide a voltage fault. Both intervals are parameters counted in clock cycles.

The state machine has six states:
- STANDBY: the input is below the undervoltage level.
- QUAL: the qualification timer runs.
- OVFLT: an overvoltage fault is present.
- START: the switch is closed and the flag is still blanked.
- ON: normal operation.
- DIS: the block is shut down by the enable pin.

The transitions, in priority order, are:
- Any state goes to STANDBY when the undervoltage-OK level is low.
- STANDBY goes to QUAL when enabled, and to DIS when not.
- QUAL goes to DIS when disabled. When its timer expires it goes to OVFLT if overvoltage is present, and to START if not.
- OVFLT goes to QUAL or DIS once the overvoltage clears, depending on the enable pin.
- START and ON go to OVFLT on overvoltage, then to DIS when disabled.
- START goes to ON when its blanking timer expires.
- DIS goes to OVFLT on overvoltage, and to QUAL when enabled.

Top module: `supply_seq_ctrl`

## Requirements
- R1: In STANDBY, entered while the undervoltage-OK level is low, gate_on is 0 and flag_low_req is 1.
- R2: After the undervoltage-OK level rises with enable_n low, gate_on rises exactly QUAL_CYCLES+3 rising edges after the input change. An overvoltage pulse that ends before the qualification interval expires has no effect on that timing.
- R3: If overvoltage is present when qualification ends, gate_on stays 0 and flag_low_req stays 1 until the overvoltage clears. The full qualification interval then runs again, so gate_on rises QUAL_CYCLES+3 edges after the overvoltage input falls.
- R4: When gate_on rises, flag_low_req is still 1. flag_low_req falls exactly BLANK_CYCLES rising edges later.
- R5: In ON, gate_on is 1 and flag_low_req is 0.
- R6: An overvoltage in START or ON sets gate_on to 0 and flag_low_req to 1 on the third rising edge after the input change.
- R7: A low undervoltage-OK level in any state, including START, sets gate_on to 0 and flag_low_req to 1 on the third rising edge.
- R8: enable_n high with no voltage fault gives gate_on 0 and flag_low_req 0. Driving it low again restarts the full qualification interval.
- R9: Overvoltage while disabled still drives flag_low_req to 1. When the overvoltage clears while still disabled, flag_low_req returns to 0.
- R10: A synchronous reset gives gate_on 0 and flag_low_req 1. Input changes reach the outputs through two synchronizer stages plus the state register.
- R11: Interrupting qualification with enable_n leaves no residue in the timer. After re-enable, the full QUAL_CYCLES+3 delay applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_ok_a | input | 1 | Asynchronous comparator: input above undervoltage level |
| ov_a | input | 1 | Asynchronous comparator: input above overvoltage level |
| enable_n_a | input | 1 | Asynchronous enable pin, active low |
| gate_on | output | 1 | Pass switch gate enable |
| flag_low_req | output | 1 | Request to pull the open-drain fault flag low |

## Verification
The bench builds the block with QUAL_CYCLES=9 and BLANK_CYCLES=6. These short intervals make it possible to reach every state and transition many times, and to count each interval edge by edge. Overvoltage is placed inside and after the qualification window, at blanking and while disabled. Enable is toggled mid-qualification so that timer clearing and restart lengths are measured directly.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_QUAL    = 3'd1,
        ST_OVFLT   = 3'd2,
        ST_START   = 3'd3,
        ST_ON      = 3'd4,
        ST_DIS     = 3'd5
    } seq_state_t;

    // bit positions inside the synchronized input vector
    localparam int IDX_UV  = 2;
    localparam int IDX_OV  = 1;
    localparam int IDX_ENN = 0;
    localparam int NUM_IN  = 3;

    // safe values while reset: no supply, no overvoltage, disabled
    localparam logic [NUM_IN-1:0] IN_RST_VAL = 3'b001;

endpackage

// File: rtl/supply_seq_sync.sv
module supply_seq_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_a;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/supply_seq_timer.sv
module supply_seq_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
    import supply_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       uv_ok,
    input  logic       ov,
    input  logic       en_n,
    input  logic       qual_done,
    input  logic       blank_done,
    output seq_state_t state,
    output logic       qual_run,
    output logic       blank_run,
    output logic       gate_on,
    output logic       flag_low_req
);

    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STANDBY;
        else     state_q <= state_d;
    end

    // next state: undervoltage first, then overvoltage, then enable, then timers
    always_comb begin
        state_d = state_q;
        if (!uv_ok) begin
            state_d = ST_STANDBY;
        end else begin
            unique case (state_q)
                ST_STANDBY: state_d = en_n ? ST_DIS : ST_QUAL;
                ST_QUAL: begin
                    if (en_n)           state_d = ST_DIS;
                    else if (qual_done) state_d = ov ? ST_OVFLT : ST_START;
                end
                ST_OVFLT: begin
                    if (!ov) state_d = en_n ? ST_DIS : ST_QUAL;
                end
                ST_START: begin
                    if (ov)              state_d = ST_OVFLT;
                    else if (en_n)       state_d = ST_DIS;
                    else if (blank_done) state_d = ST_ON;
                end
                ST_ON: begin
                    if (ov)        state_d = ST_OVFLT;
                    else if (en_n) state_d = ST_DIS;
                end
                ST_DIS: begin
                    if (ov)         state_d = ST_OVFLT;
                    else if (!en_n) state_d = ST_QUAL;
                end
                default: state_d = ST_STANDBY;
            endcase
        end
    end

    // outputs decoded from the present state
    always_comb begin
        gate_on      = 1'b0;
        flag_low_req = 1'b1;
        qual_run     = 1'b0;
        blank_run    = 1'b0;
        unique case (state_q)
            ST_STANDBY: ;
            ST_QUAL:    qual_run = 1'b1;
            ST_OVFLT:   ;
            ST_START: begin
                gate_on   = 1'b1;
                blank_run = 1'b1;
            end
            ST_ON: begin
                gate_on      = 1'b1;
                flag_low_req = 1'b0;
            end
            ST_DIS:     flag_low_req = 1'b0;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl
    import supply_seq_pkg::*;
#(
    parameter int QUAL_CYCLES  = 16,
    parameter int BLANK_CYCLES = 12,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_ok_a,
    input  logic ov_a,
    input  logic enable_n_a,
    output logic gate_on,
    output logic flag_low_req
);

    logic [NUM_IN-1:0] raw_in, sync_in;
    logic              uv_s, ov_s, en_n_s;
    logic              qual_run, blank_run, qual_done, blank_done;
    seq_state_t        state_q;

    assign raw_in[IDX_UV]  = uv_ok_a;
    assign raw_in[IDX_OV]  = ov_a;
    assign raw_in[IDX_ENN] = enable_n_a;

    supply_seq_sync #(
        .W       (NUM_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_RST_VAL)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d_a (raw_in),
        .q   (sync_in)
    );

    assign uv_s   = sync_in[IDX_UV];
    assign ov_s   = sync_in[IDX_OV];
    assign en_n_s = sync_in[IDX_ENN];

    supply_seq_timer #(.CYCLES(QUAL_CYCLES)) i_qual_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (qual_run),
        .done (qual_done)
    );

    supply_seq_timer #(.CYCLES(BLANK_CYCLES)) i_blank_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (blank_run),
        .done (blank_done)
    );

    supply_seq_fsm i_fsm (
        .clk          (clk),
        .rst          (rst),
        .uv_ok        (uv_s),
        .ov           (ov_s),
        .en_n         (en_n_s),
        .qual_done    (qual_done),
        .blank_done   (blank_done),
        .state        (state_q),
        .qual_run     (qual_run),
        .blank_run    (blank_run),
        .gate_on      (gate_on),
        .flag_low_req (flag_low_req)
    );

endmodule

// File: rtl/supply_seq_chk.sv
module supply_seq_chk
    import supply_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       gate_on,
    input logic       flag_low_req,
    input seq_state_t state,
    input logic       uv_s,
    input logic       ov_s,
    input logic       en_n_s
);

    // R7
    uv_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !uv_s |=> (state == ST_STANDBY) && !gate_on && flag_low_req);

    // R2
    gate_after_qual_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> ($past(state) == ST_QUAL));

    // R4
    flag_blanked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> flag_low_req);

    // R5
    release_after_blank_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag_low_req) && gate_on) |-> ($past(state) == ST_START));

    // R6
    ov_trip_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ON || state == ST_START) && uv_s && ov_s)
        |=> !gate_on && flag_low_req);

    // R8
    shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ON) && uv_s && !ov_s && en_n_s)
        |=> !gate_on && !flag_low_req);

    // R9
    no_override_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_DIS) && uv_s && ov_s) |=> flag_low_req && !gate_on);

endmodule

bind supply_seq_ctrl supply_seq_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .gate_on      (gate_on),
    .flag_low_req (flag_low_req),
    .state        (state_q),
    .uv_s         (uv_s),
    .ov_s         (ov_s),
    .en_n_s       (en_n_s)
);

// File: tb/test_supply_seq_ctrl.sv
`timescale 1ns/1ps
module test_supply_seq_ctrl;

    localparam int QUAL  = 9;
    localparam int BLANK = 6;

    localparam int M_STBY = 0, M_QUAL = 1, M_OVF = 2, M_START = 3, M_ON = 4, M_DIS = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uv_in = 1'b0, ov_in = 1'b0, en_n_in = 1'b1;
    logic gate_on, flag_low_req;

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    supply_seq_ctrl #(.QUAL_CYCLES(QUAL), .BLANK_CYCLES(BLANK)) i_supply_seq_ctrl (
        .clk          (clk),
        .rst          (rst),
        .uv_ok_a      (uv_in),
        .ov_a         (ov_in),
        .enable_n_a   (en_n_in),
        .gate_on      (gate_on),
        .flag_low_req (flag_low_req)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: input samples delayed through a queue, integer state
    logic [2:0] pipe[$];
    int m_state = M_STBY;
    int m_time  = 0;

    always @(posedge clk) begin
        logic [2:0] seen;
        int nxt;
        if (rst) begin
            pipe.delete();
            m_state = M_STBY;
            m_time  = 0;
        end else begin
            pipe.push_back({uv_in, ov_in, en_n_in});
            seen = (pipe.size() > 2) ? pipe.pop_front() : 3'b001;
            nxt = m_state;
            if (!seen[2]) nxt = M_STBY;
            else if (m_state == M_STBY) nxt = seen[0] ? M_DIS : M_QUAL;
            else if (m_state == M_QUAL) begin
                if (seen[0]) nxt = M_DIS;
                else if (m_time == QUAL - 1) nxt = seen[1] ? M_OVF : M_START;
            end else if (m_state == M_OVF) begin
                if (!seen[1]) nxt = seen[0] ? M_DIS : M_QUAL;
            end else if (m_state == M_START) begin
                if (seen[1]) nxt = M_OVF;
                else if (seen[0]) nxt = M_DIS;
                else if (m_time == BLANK - 1) nxt = M_ON;
            end else if (m_state == M_ON) begin
                if (seen[1]) nxt = M_OVF;
                else if (seen[0]) nxt = M_DIS;
            end else begin
                if (seen[1]) nxt = M_OVF;
                else if (!seen[0]) nxt = M_QUAL;
            end
            m_time  = (nxt == m_state) ? m_time + 1 : 0;
            m_state = nxt;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            string tag;
            logic eg, ef;
            case (m_state)
                M_STBY:  tag = "R1";
                M_QUAL:  tag = "R2";
                M_OVF:   tag = "R3";
                M_START: tag = "R4";
                M_ON:    tag = "R5";
                default: tag = "R8";
            endcase
            eg = (m_state == M_START || m_state == M_ON);
            ef = !(m_state == M_ON || m_state == M_DIS);
            check(tag, gate_on, eg, "model gate");
            check(tag, flag_low_req, ef, "model flag");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges_until_gate(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (gate_on !== val && n < 1000);
    endtask

    task automatic edges_until_flag(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (flag_low_req !== val && n < 1000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int n;
        step(4);
        check("R10", gate_on, 1'b0, "reset gate");
        check("R10", flag_low_req, 1'b1, "reset flag");
        rst = 1'b0;
        step(3);
        check("R1", flag_low_req, 1'b1, "standby flag");

        // normal power-up
        en_n_in = 1'b0; uv_in = 1'b1;
        edges_until_gate(1'b1, n);
        check_int("R2", n, QUAL + 3, "edges to gate on");
        check("R4", flag_low_req, 1'b1, "flag held at gate on");
        edges_until_flag(1'b0, n);
        check_int("R4", n, BLANK, "blanking length");
        step(3);
        check("R5", gate_on, 1'b1, "on gate");

        // overvoltage in ON
        ov_in = 1'b1;
        edges_until_gate(1'b0, n);
        check_int("R6", n, 3, "trip latency");
        check("R6", flag_low_req, 1'b1, "flag on trip");
        step(4);
        ov_in = 1'b0;
        edges_until_gate(1'b1, n);
        check_int("R3", n, QUAL + 3, "requalify after ov");
        step(2);
        // undervoltage during blanking
        uv_in = 1'b0;
        edges_until_gate(1'b0, n);
        check_int("R7", n, 3, "uv latency in start");
        check("R7", flag_low_req, 1'b1, "uv flag");
        step(3);

        // overvoltage present at end of qualification
        ov_in = 1'b1; uv_in = 1'b1;
        step(QUAL + 5);
        check("R3", gate_on, 1'b0, "ov held gate");
        check("R3", flag_low_req, 1'b1, "ov held flag");
        ov_in = 1'b0;
        edges_until_gate(1'b1, n);
        check_int("R3", n, QUAL + 3, "gate after ov clear");
        step(BLANK + 3);

        // shutdown, ov while disabled, re-enable
        en_n_in = 1'b1;
        step(4);
        check("R8", gate_on, 1'b0, "disabled gate");
        check("R8", flag_low_req, 1'b0, "disabled flag");
        ov_in = 1'b1;
        step(4);
        check("R9", flag_low_req, 1'b1, "ov visible while disabled");
        ov_in = 1'b0;
        step(4);
        check("R9", flag_low_req, 1'b0, "flag after ov clear disabled");
        en_n_in = 1'b0;
        edges_until_gate(1'b1, n);
        check_int("R8", n, QUAL + 3, "restart after enable");
        step(BLANK + 2);

        // ov pulse inside the qualification window is ignored
        uv_in = 1'b0; step(5);
        uv_in = 1'b1; step(4);
        ov_in = 1'b1; step(2);
        ov_in = 1'b0;
        edges_until_gate(1'b1, n);
        check_int("R2", n + 6, QUAL + 3, "ov pulse in qual ignored");
        step(BLANK + 2);

        // qualification interrupted by enable
        uv_in = 1'b0; step(5);
        uv_in = 1'b1; step(5);
        en_n_in = 1'b1; step(3);
        en_n_in = 1'b0;
        edges_until_gate(1'b1, n);
        check_int("R11", n, QUAL + 3, "full qual after interruption");
        step(BLANK + 3);

        done_flag = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule